// File: doc/BRIEF.md
# Multiple-Issue Hazard Check Unit

This block sits between the decoded-instruction queue and the execution units of an in-order superscalar front end. It holds a small window of up to N decoded instructions (N = 2 by default). Every cycle it issues the longest in-order run of them that can start together. It checks operands against results still in flight and against older members of the same group, and it limits each cycle to one memory operation and one floating-point operation.

Instructions that were not issued move down to the lowest window positions, so the oldest survivor is the first one considered in the next cycle. Free positions are refilled from a fetch port that is up to N lanes wide and uses a per-lane valid/ready handshake. A lane is refused while its slot is still occupied. Pending-write tracking counts down a result latency for each instruction class. With the default latencies of one cycle, a consumer can issue in the cycle after its producer.

Top module: `hz_issue_unit`

## Requirements
- R1: No cycle issues more than one instruction of the memory class (class code 1).
- R2: No cycle issues more than one floating-point instruction, where multiply (class code 2) and add (class code 3) together count as one group.
- R3: `issue_count` lies between 0 and N and equals the number of set bits in `issue_valid`. A group with no hazard issues completely.
- R4: Issue is in order. Lane k is valid only if every older lane is valid, so a blocked instruction also holds back every younger one.
- R5: The instruction word is {class[11:10], write_enable[9], dst[8:6], src_a[5:3], src_b[2:0]}, with class 0 = integer. A younger instruction is held in its cycle if src_a or src_b names the dst of an older instruction in the same group whose write_enable is 1.
- R6: With one-cycle latencies, a held consumer issues in the next cycle. A source that matches the dst of an older instruction whose write_enable is 0 causes no hold.
- R7: Instructions that were not issued shift to the head of the window. The oldest survivor appears on lane 0 in the next cycle.
- R8: `fetch_ready[i]` is 1 exactly when i is less than the number of free slots at the start of the cycle, so it is all zero when the window is full. Accepted instructions issue no earlier than the next cycle, in lane order, behind the survivors.
- R9: A synchronous reset empties the window and clears pending writes. In the cycle after reset, `issue_count` is 0 and `fetch_ready` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_valid | input | N | Lane-valid flags of the offered instructions, set as a prefix from lane 0 |
| fetch_ready | output | N | Lane accepted this cycle |
| fetch_instr | input | N*12 | Offered instruction words, lane 0 in the low bits |
| issue_valid | output | N | Lanes issued this cycle |
| issue_instr | output | N*12 | Window contents by lane, oldest in lane 0 |
| issue_count | output | clog2(N+1) | Number of instructions issued this cycle |

## Verification
If the window loses its place during compaction, a wrong or repeated word appears on lane 0 in the very next cycle after a partial issue. A corrupted occupancy count shows up at once as a wrong `fetch_ready` pattern. A stuck pending-write counter makes a dependent instruction stall in the cycle when it should issue. Each pairing of classes and dependency pattern is therefore checked in the issue cycle and again in the following cycle.

// File: rtl/hz_pkg.sv
package hz_pkg;
    typedef enum logic [1:0] {
        CLS_INT  = 2'd0,
        CLS_MEM  = 2'd1,
        CLS_FMUL = 2'd2,
        CLS_FADD = 2'd3
    } hz_cls_e;

    localparam int HZ_NREG = 8;
    localparam int HZ_RW   = $clog2(HZ_NREG);

    // Word layout: class, write enable, destination, source a, source b (MSB first).
    typedef struct packed {
        hz_cls_e          cls;
        logic             wr_en;
        logic [HZ_RW-1:0] dst;
        logic [HZ_RW-1:0] src_a;
        logic [HZ_RW-1:0] src_b;
    } hz_instr_t;

    localparam int HZ_IW = $bits(hz_instr_t);

    function automatic logic is_fp(hz_cls_e c);
        return (c == CLS_FMUL) || (c == CLS_FADD);
    endfunction
endpackage

// File: rtl/hz_window.sv
module hz_window
    import hz_pkg::*;
#(
    parameter int N = 2,
    localparam int CW = $clog2(N + 1)
) (
    input  logic      clk,
    input  logic      rst,
    input  logic [CW-1:0] issue_cnt,
    input  logic [N-1:0]  fetch_valid,
    input  hz_instr_t fetch_word [N],
    output logic [N-1:0]  fetch_ready,
    output logic [N-1:0]  slot_valid,
    output hz_instr_t slot_word [N]
);
    logic [N-1:0] valid_q, valid_d;
    hz_instr_t    word_q [N];
    hz_instr_t    word_d [N];
    logic [N-1:0] take;

    always_comb begin
        int occ;
        int free_n;
        int keep;
        int src;
        int k;
        logic more;
        occ = 0;
        for (int i = 0; i < N; i++) begin
            if (valid_q[i]) occ = occ + 1;
        end
        free_n = N - occ;
        more = 1'b1;
        for (int i = 0; i < N; i++) begin
            fetch_ready[i] = (i < free_n);
            take[i] = more && fetch_valid[i] && (i < free_n);
            more = take[i];
        end
        keep = occ - int'(issue_cnt);
        valid_d = '0;
        for (int d = 0; d < N; d++) begin
            word_d[d] = '0;
            src = d + int'(issue_cnt);
            k = d - keep;
            if (src < occ) begin
                word_d[d]  = word_q[src];
                valid_d[d] = 1'b1;
            end else if (k >= 0 && k < N) begin
                if (take[k]) begin
                    word_d[d]  = fetch_word[k];
                    valid_d[d] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            for (int i = 0; i < N; i++) word_q[i] <= '0;
        end else begin
            valid_q <= valid_d;
            for (int i = 0; i < N; i++) word_q[i] <= word_d[i];
        end
    end

    assign slot_valid = valid_q;
    always_comb begin
        for (int i = 0; i < N; i++) slot_word[i] = word_q[i];
    end
endmodule

// File: rtl/hz_pending.sv
module hz_pending
    import hz_pkg::*;
#(
    parameter int N        = 2,
    parameter int LAT_INT  = 1,
    parameter int LAT_MEM  = 1,
    parameter int LAT_FMUL = 1,
    parameter int LAT_FADD = 1,
    localparam int MAXL01 = (LAT_INT > LAT_MEM) ? LAT_INT : LAT_MEM,
    localparam int MAXL23 = (LAT_FMUL > LAT_FADD) ? LAT_FMUL : LAT_FADD,
    localparam int MAXL   = (MAXL01 > MAXL23) ? MAXL01 : MAXL23,
    localparam int TW     = $clog2(MAXL + 1)
) (
    input  logic      clk,
    input  logic      rst,
    input  logic [N-1:0] go,
    input  hz_instr_t word [N],
    output logic [HZ_NREG-1:0] busy
);
    logic [TW-1:0] left_q [HZ_NREG];

    function automatic logic [TW-1:0] wait_of(hz_cls_e c);
        case (c)
            CLS_MEM:  return TW'(LAT_MEM - 1);
            CLS_FMUL: return TW'(LAT_FMUL - 1);
            CLS_FADD: return TW'(LAT_FADD - 1);
            default:  return TW'(LAT_INT - 1);
        endcase
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < HZ_NREG; r++) left_q[r] <= '0;
        end else begin
            for (int r = 0; r < HZ_NREG; r++) begin
                if (left_q[r] != '0) left_q[r] <= left_q[r] - TW'(1);
            end
            for (int k = 0; k < N; k++) begin
                if (go[k] && word[k].wr_en) left_q[word[k].dst] <= wait_of(word[k].cls);
            end
        end
    end

    for (genvar r = 0; r < HZ_NREG; r++) begin : g_busy
        assign busy[r] = (left_q[r] != '0);
    end
endmodule

// File: rtl/hz_select.sv
module hz_select
    import hz_pkg::*;
#(
    parameter int N = 2,
    localparam int CW = $clog2(N + 1)
) (
    input  logic [N-1:0] slot_valid,
    input  hz_instr_t    slot_word [N],
    input  logic [HZ_NREG-1:0] busy,
    output logic [N-1:0] go,
    output logic [CW-1:0] go_cnt
);
    always_comb begin
        logic chain;
        logic ok;
        chain  = 1'b1;
        go_cnt = '0;
        for (int k = 0; k < N; k++) begin
            ok = chain && slot_valid[k];
            if (busy[slot_word[k].src_a] || busy[slot_word[k].src_b]) ok = 1'b0;
            for (int j = 0; j < k; j++) begin
                if (slot_word[j].wr_en &&
                    (slot_word[j].dst == slot_word[k].src_a ||
                     slot_word[j].dst == slot_word[k].src_b)) ok = 1'b0;
                if (slot_word[j].cls == CLS_MEM && slot_word[k].cls == CLS_MEM) ok = 1'b0;
                if (is_fp(slot_word[j].cls) && is_fp(slot_word[k].cls)) ok = 1'b0;
            end
            go[k] = ok;
            chain = ok;
            if (ok) go_cnt = go_cnt + CW'(1);
        end
    end
endmodule

// File: rtl/hz_issue_unit.sv
module hz_issue_unit
    import hz_pkg::*;
#(
    parameter int N        = 2,
    parameter int LAT_INT  = 1,
    parameter int LAT_MEM  = 1,
    parameter int LAT_FMUL = 1,
    parameter int LAT_FADD = 1,
    localparam int CW = $clog2(N + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N-1:0]       fetch_valid,
    output logic [N-1:0]       fetch_ready,
    input  logic [N*HZ_IW-1:0] fetch_instr,
    output logic [N-1:0]       issue_valid,
    output logic [N*HZ_IW-1:0] issue_instr,
    output logic [CW-1:0]      issue_count
);
    hz_instr_t    in_word [N];
    hz_instr_t    slot_word [N];
    logic [N-1:0] slot_valid;
    logic [N-1:0] go;
    logic [CW-1:0] go_cnt;
    logic [HZ_NREG-1:0] busy;

    for (genvar k = 0; k < N; k++) begin : g_lane
        assign in_word[k] = hz_instr_t'(fetch_instr[k*HZ_IW +: HZ_IW]);
        assign issue_instr[k*HZ_IW +: HZ_IW] = slot_word[k];
    end

    hz_window #(.N(N)) u_window (
        .clk(clk), .rst(rst), .issue_cnt(go_cnt),
        .fetch_valid(fetch_valid), .fetch_word(in_word), .fetch_ready(fetch_ready),
        .slot_valid(slot_valid), .slot_word(slot_word)
    );

    hz_pending #(.N(N), .LAT_INT(LAT_INT), .LAT_MEM(LAT_MEM),
                 .LAT_FMUL(LAT_FMUL), .LAT_FADD(LAT_FADD)) u_pending (
        .clk(clk), .rst(rst), .go(go), .word(slot_word), .busy(busy)
    );

    hz_select #(.N(N)) u_select (
        .slot_valid(slot_valid), .slot_word(slot_word), .busy(busy),
        .go(go), .go_cnt(go_cnt)
    );

    assign issue_valid = go;
    assign issue_count = go_cnt;
endmodule

// File: rtl/hz_issue_chk.sv
module hz_issue_chk
    import hz_pkg::*;
#(
    parameter int N = 2,
    localparam int CW = $clog2(N + 1)
) (
    input logic               clk,
    input logic               rst,
    input logic [N-1:0]       fetch_ready,
    input logic [N-1:0]       issue_valid,
    input logic [N*HZ_IW-1:0] issue_instr,
    input logic [CW-1:0]      issue_count
);
    int   n_mem;
    int   n_fp;
    logic raw_hit;

    always_comb begin
        hz_instr_t a;
        hz_instr_t b;
        n_mem = 0;
        n_fp = 0;
        raw_hit = 1'b0;
        for (int k = 0; k < N; k++) begin
            a = hz_instr_t'(issue_instr[k*HZ_IW +: HZ_IW]);
            if (issue_valid[k] && a.cls == CLS_MEM) n_mem = n_mem + 1;
            if (issue_valid[k] && is_fp(a.cls)) n_fp = n_fp + 1;
            for (int j = 0; j < k; j++) begin
                b = hz_instr_t'(issue_instr[j*HZ_IW +: HZ_IW]);
                if (issue_valid[k] && issue_valid[j] && b.wr_en &&
                    (b.dst == a.src_a || b.dst == a.src_b)) raw_hit = 1'b1;
            end
        end
    end

    assert_one_mem_R1: assert property (@(posedge clk) disable iff (rst) n_mem <= 1);
    assert_one_fp_R2: assert property (@(posedge clk) disable iff (rst) n_fp <= 1);
    assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
        int'(issue_count) <= N);
    assert_count_match_R3: assert property (@(posedge clk) disable iff (rst)
        $countones(issue_valid) == int'(issue_count));
    assert_in_order_R4: assert property (@(posedge clk) disable iff (rst)
        ((issue_valid + N'(1)) & issue_valid) == '0);
    assert_no_group_raw_R5: assert property (@(posedge clk) disable iff (rst) !raw_hit);
    assert_ready_prefix_R8: assert property (@(posedge clk) disable iff (rst)
        ((fetch_ready + N'(1)) & fetch_ready) == '0);
    assert_reset_idle_R9: assert property (@(posedge clk)
        rst |=> (issue_count == '0 && fetch_ready == '1));
endmodule

bind hz_issue_unit hz_issue_chk #(.N(N)) u_chk (
    .clk(clk), .rst(rst), .fetch_ready(fetch_ready), .issue_valid(issue_valid),
    .issue_instr(issue_instr), .issue_count(issue_count)
);

// File: tb/hz_issue_unit_tb.sv
module hz_issue_unit_tb;
    localparam int N  = 2;
    localparam int IW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  fetch_valid = '0;
    logic [N-1:0]  fetch_ready;
    logic [N*IW-1:0] fetch_instr = '0;
    logic [N-1:0]  issue_valid;
    logic [N*IW-1:0] issue_instr;
    logic [1:0]    issue_count;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    hz_issue_unit u_dut (
        .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
        .fetch_instr(fetch_instr), .issue_valid(issue_valid),
        .issue_instr(issue_instr), .issue_count(issue_count)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] mk(int cls, int we, int d, int a, int b);
        return {2'(cls), 1'(we), 3'(d), 3'(a), 3'(b)};
    endfunction

    function automatic bit fp(int c);
        return c == 2 || c == 3;
    endfunction

    task automatic run_pair(input int ca, input int cb, input int mode);
        logic [11:0] wa, wb;
        int  ea, eb, ex;
        bit  raw;
        string tag;
        ea = (mode == 1 || mode == 3) ? 5 : 3;
        eb = (mode == 2) ? 5 : 4;
        wa = mk(ca, (mode != 3) ? 1 : 0, 5, 1, 2);
        wb = mk(cb, 1, 6, ea, eb);
        raw = (mode == 1 || mode == 2);
        if (raw) begin ex = 1; tag = "R5"; end
        else if (ca == 1 && cb == 1) begin ex = 1; tag = "R1"; end
        else if (fp(ca) && fp(cb)) begin ex = 1; tag = "R2"; end
        else begin ex = 2; tag = (mode == 3) ? "R6" : "R3"; end
        @(negedge clk);
        fetch_valid = 2'b11;
        fetch_instr = {wb, wa};
        @(negedge clk);
        fetch_valid = 2'b00;
        check(fetch_ready == 2'b00, "R8 full window ready", int'(fetch_ready), 0);
        check(int'(issue_count) == ex, tag, int'(issue_count), ex);
        check(issue_valid == ((ex == 2) ? 2'b11 : 2'b01), "R4 issue lanes",
              int'(issue_valid), (ex == 2) ? 3 : 1);
        check(issue_instr[IW-1:0] == wa, "R3 lane0 word", int'(issue_instr[IW-1:0]), int'(wa));
        @(negedge clk);
        if (ex == 1) begin
            check(issue_count == 2'd1, raw ? "R6 consumer next cycle" : "R7 survivor issues",
                  int'(issue_count), 1);
            check(issue_instr[IW-1:0] == wb, "R7 survivor at head",
                  int'(issue_instr[IW-1:0]), int'(wb));
            check(fetch_ready == 2'b01, "R8 one free slot", int'(fetch_ready), 1);
        end else begin
            check(issue_count == 2'd0, "R3 window empty", int'(issue_count), 0);
            check(fetch_ready == 2'b11, "R8 two free slots", int'(fetch_ready), 3);
        end
    endtask

    initial begin
        logic [11:0] wa, wb, wc;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(issue_count == 2'd0, "R9 reset count", int'(issue_count), 0);
        check(issue_valid == 2'b00, "R9 reset lanes", int'(issue_valid), 0);
        check(fetch_ready == 2'b11, "R9 reset ready", int'(fetch_ready), 3);

        for (int ca = 0; ca < 4; ca++)
            for (int cb = 0; cb < 4; cb++)
                for (int m = 0; m < 4; m++)
                    run_pair(ca, cb, m);

        // refill behind a survivor
        wa = mk(1, 1, 2, 0, 1);
        wb = mk(1, 1, 3, 4, 5);
        wc = mk(0, 1, 7, 2, 3);
        @(negedge clk);
        fetch_valid = 2'b11;
        fetch_instr = {wb, wa};
        @(negedge clk);
        fetch_valid = 2'b00;
        check(issue_count == 2'd1, "R1 two memory ops", int'(issue_count), 1);
        @(negedge clk);
        check(fetch_ready == 2'b01, "R8 ready after partial", int'(fetch_ready), 1);
        fetch_valid = 2'b01;
        fetch_instr = {12'h000, wc};
        @(negedge clk);
        fetch_valid = 2'b00;
        check(issue_count == 2'd1, "R8 appended word alone", int'(issue_count), 1);
        check(issue_instr[IW-1:0] == wc, "R8 appended order",
              int'(issue_instr[IW-1:0]), int'(wc));
        @(negedge clk);
        check(issue_count == 2'd0, "R8 drained", int'(issue_count), 0);

        // single lane offer
        @(negedge clk);
        fetch_valid = 2'b01;
        fetch_instr = {12'h000, wc};
        @(negedge clk);
        fetch_valid = 2'b00;
        check(issue_count == 2'd1, "R3 single lane", int'(issue_count), 1);
        check(issue_valid == 2'b01, "R4 single lane pattern", int'(issue_valid), 1);

        // reset with a held pair
        @(negedge clk);
        fetch_valid = 2'b11;
        fetch_instr = {mk(2, 1, 1, 0, 0), mk(3, 1, 2, 0, 0)};
        @(negedge clk);
        fetch_valid = 2'b00;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(issue_count == 2'd0, "R9 reset flushes", int'(issue_count), 0);
        check(fetch_ready == 2'b11, "R9 reset frees", int'(fetch_ready), 3);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule